// File: doc/BRIEF.md
# Packed Vector Saturating Add/Subtract Unit

This unit performs lane-wise saturating addition or subtraction on two packed operand vectors. At run time a select chooses the lane width (8, 16, 32 or 64 bits), the signedness and the operation. Each lane is computed on its own. When a lane's true result falls outside the range that lane can hold, the lane is clamped to the nearest limit. The clamp values are all-ones or zero for unsigned lanes, and the most positive or most negative value for signed lanes.

An active-length input gives, in bytes, how much of the vector is live. Result bytes from that length up to the full vector width are forced to zero. Lanes lying beyond the length cannot raise the saturation indication. A single sticky flag records that at least one clamp has happened since it was last cleared. A synchronous clear input resets the flag. One cycle after an operation is accepted, the registered result and the updated flag appear together with a valid strobe.

Top module: `vsat_addsub`

## Requirements
- R1: With unsigned add selected (op_sub=0, op_signed=0), a lane whose true sum exceeds the lane's largest unsigned value returns the all-ones lane value.
- R2: With unsigned subtract selected (op_sub=1, op_signed=0), a lane whose first operand is smaller than its second returns zero.
- R3: With signed operation selected (op_signed=1), an overflowing lane returns the most negative value when the first operand is negative, and the most positive value otherwise.
- R4: A lane whose true result fits in its range returns the exact sum or difference, modulo the lane width, and does not set the flag.
- R5: elem_sz selects the lane width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Lanes never carry into each other.
- R6: The sticky flag becomes 1 after any accepted operation in which an active lane clamps. An operation with no clamp leaves the flag at its previous value.
- R7: flag_clr drives the flag to 0 on the next cycle. When flag_clr coincides with an accepted operation that clamps, the flag becomes 1 instead.
- R8: A result byte at index i (byte 0 = bits 7:0) is zero whenever i >= act_len. Lanes starting at or beyond act_len do not affect the flag.
- R9: out_valid is high exactly in the cycle after in_valid. The result is registered on accepted operations and holds between them.
- R10: After reset, out_valid, result and the flag are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept an operation this cycle |
| opnd_a | input | 128 | First packed operand |
| opnd_b | input | 128 | Second packed operand |
| elem_sz | input | 2 | Lane width select (0:8, 1:16, 2:32, 3:64 bits) |
| op_signed | input | 1 | 1 = signed lanes, 0 = unsigned |
| op_sub | input | 1 | 1 = a minus b, 0 = a plus b |
| act_len | input | 5 | Number of live bytes, multiple of 8, up to 16 |
| flag_clr | input | 1 | Synchronous clear of the sticky flag |
| out_valid | output | 1 | Result valid strobe |
| result | output | 128 | Clamped, tail-zeroed result |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
Each lane width is driven with its edge operands: the maximum plus one, the minimum minus one and the maximum plus the maximum. These separate the unsigned carry and borrow clamps from the two signed clamp directions. Even lanes hold the boundary case and odd lanes hold small benign values, so a carry leaking between lanes or a wrong lane boundary shows up. Near-limit pairs that do not overflow, such as maximum plus minimum, tell a correct overflow rule apart from one that clamps too eagerly. Pseudo-random patterns over every width and mode, and a half-length vector with clamping only in its dead upper half, separate tail masking and flag gating from the arithmetic itself.

// File: rtl/vsat_addsub.sv
module vsat_addsub #(
  parameter int VB = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [VB*8-1:0]          opnd_a,
  input  logic [VB*8-1:0]          opnd_b,
  input  logic [1:0]               elem_sz,
  input  logic                     op_signed,
  input  logic                     op_sub,
  input  logic [$clog2(VB+1)-1:0]  act_len,
  input  logic                     flag_clr,
  output logic                     out_valid,
  output logic [VB*8-1:0]          result,
  output logic                     sat_flag
);
  localparam int VW = VB * 8;
  localparam int LW = $clog2(VB + 1);

  logic [3:0][VW-1:0] lane_res;
  logic [3:0][VB-1:0] lane_clip;
  logic [VW-1:0]      sel_res, nxt_res;
  logic [VB-1:0]      keep;
  logic               any_clip;

  for (genvar gw = 0; gw < 4; gw++) begin : g_w
    localparam int W   = 8 << gw;
    localparam int N   = VW / W;
    localparam int BPL = W / 8;
    for (genvar gl = 0; gl < N; gl++) begin : g_l
      logic [W-1:0] xa, xb, raw, sat_val;
      logic         ucarry, sovf, clip;
      assign xa = opnd_a[gl*W +: W];
      assign xb = opnd_b[gl*W +: W];
      assign {ucarry, raw} = op_sub ? {1'b0, xa} - {1'b0, xb}
                                    : {1'b0, xa} + {1'b0, xb};
      assign sovf = (op_sub ? (xa[W-1] != xb[W-1]) : (xa[W-1] == xb[W-1]))
                    && (raw[W-1] != xa[W-1]);
      assign clip = op_signed ? sovf : ucarry;
      always_comb begin
        if (op_signed) sat_val = {xa[W-1], {(W-1){~xa[W-1]}}};
        else           sat_val = op_sub ? '0 : '1;
      end
      assign lane_res[gw][gl*W +: W]      = clip ? sat_val : raw;
      assign lane_clip[gw][gl*BPL +: BPL] = {BPL{clip}};
    end
  end

  assign sel_res = lane_res[elem_sz];

  for (genvar gb = 0; gb < VB; gb++) begin : g_b
    assign keep[gb] = LW'(gb) < act_len;
    assign nxt_res[gb*8 +: 8] = keep[gb] ? sel_res[gb*8 +: 8] : 8'h00;

    // R8
    tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && act_len <= LW'(gb)) |=> (result[gb*8 +: 8] == 8'h00));
  end

  assign any_clip = |(lane_clip[elem_sz] & keep);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      sat_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt_res;
      if (in_valid && any_clip) sat_flag <= 1'b1;
      else if (flag_clr)        sat_flag <= 1'b0;
    end
  end

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R9
  no_stray_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result)));
  // R6
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag && !flag_clr) |=> sat_flag);
  // R6
  sat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && any_clip) |=> sat_flag);
  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !in_valid) |=> !sat_flag);
  // R6
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sat_flag) |-> $past(in_valid));
endmodule

// File: tb/sim_vsat_addsub.sv
module sim_vsat_addsub;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] opnd_a = '0, opnd_b = '0;
  logic [1:0]   elem_sz = '0;
  logic         op_signed = 1'b0, op_sub = 1'b0;
  logic [4:0]   act_len = 5'd16;
  logic         flag_clr = 1'b0;
  logic         out_valid, sat_flag;
  logic [127:0] result;

  int  checks = 0, errors = 0;
  bit  exp_flag = 1'b0;
  logic [31:0] lfsr = 32'h1234_5678;

  vsat_addsub u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .elem_sz(elem_sz), .op_signed(op_signed), .op_sub(op_sub),
    .act_len(act_len), .flag_clr(flag_clr), .out_valid(out_valid),
    .result(result), .sat_flag(sat_flag)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model(input logic [127:0] a, input logic [127:0] b, input logic [1:0] es,
                       input logic sg, input logic sb, input logic [4:0] len,
                       output logic [127:0] r, output bit clip);
    int w = 8 << es;
    r = '0; clip = 1'b0;
    for (int l = 0; l < 128 / w; l++) begin
      logic signed [66:0] xa, xb, x, lo, hi;
      bit c = 1'b0;
      xa = '0; xb = '0;
      for (int k = 0; k < 67; k++) begin
        if (k < w) begin xa[k] = a[l*w+k]; xb[k] = b[l*w+k]; end
        else if (sg) begin xa[k] = a[l*w+w-1]; xb[k] = b[l*w+w-1]; end
      end
      x  = sb ? xa - xb : xa + xb;
      hi = sg ? (67'sd1 << (w-1)) - 67'sd1 : (67'sd1 << w) - 67'sd1;
      lo = sg ? -(67'sd1 << (w-1)) : 67'sd0;
      if (x > hi) begin x = hi; c = 1'b1; end
      else if (x < lo) begin x = lo; c = 1'b1; end
      for (int k = 0; k < w; k++) r[l*w+k] = x[k];
      if ((l * w / 8) < len) clip = clip | c;
    end
    for (int i = 0; i < 16; i++) if (i >= len) r[i*8 +: 8] = 8'h00;
  endtask

  task automatic run_op(input logic [127:0] a, input logic [127:0] b, input logic [1:0] es,
                        input logic sg, input logic sb, input logic [4:0] len,
                        input logic clr, input string tag);
    logic [127:0] er;
    bit c;
    model(a, b, es, sg, sb, len, er, c);
    @(negedge clk);
    opnd_a = a; opnd_b = b; elem_sz = es; op_signed = sg; op_sub = sb;
    act_len = len; flag_clr = clr; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; flag_clr = 1'b0;
    exp_flag = c ? 1'b1 : (clr ? 1'b0 : exp_flag);
    check({tag, " R9 out_valid"}, {127'd0, out_valid}, 128'd1);
    check({tag, " result"}, result, er);
    check({tag, " flag"}, {127'd0, sat_flag}, {127'd0, exp_flag});
  endtask

  function automatic logic [127:0] fill(input logic [63:0] ev, input logic [63:0] od,
                                        input logic [1:0] es);
    int w = 8 << es;
    logic [127:0] v = '0;
    for (int l = 0; l < 128 / w; l++)
      for (int k = 0; k < w; k++) v[l*w+k] = (l % 2 == 0) ? ev[k] : od[k];
    return v;
  endfunction

  function automatic logic [127:0] rnd128();
    logic [127:0] v;
    for (int i = 0; i < 4; i++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      v[i*32 +: 32] = lfsr;
    end
    return v;
  endfunction

  task automatic t_reset();
    check("R10 out_valid", {127'd0, out_valid}, 128'd0);
    check("R10 result", result, 128'd0);
    check("R10 flag", {127'd0, sat_flag}, 128'd0);
  endtask

  task automatic t_boundaries();
    for (int e = 0; e < 4; e++) begin
      logic [1:0]  es = 2'(e);
      int          w = 8 << e;
      logic [63:0] umax = (w == 64) ? '1 : (64'd1 << w) - 64'd1;
      logic [63:0] smax = umax >> 1;
      logic [63:0] smin = smax + 64'd1;
      logic [63:0] bn = 64'd3, bm = 64'd2;
      run_op(fill(umax, bn, es), fill(64'd1, bm, es), es, 0, 0, 16, 1, "R1 umax+1");
      run_op(fill(umax, bn, es), fill(umax, bm, es), es, 0, 0, 16, 1, "R1 umax+umax");
      run_op(fill(64'd0, bn, es), fill(64'd1, bm, es), es, 0, 1, 16, 1, "R2 0-1");
      run_op(fill(smax, bn, es), fill(64'd1, bm, es), es, 1, 0, 16, 1, "R3 smax+1");
      run_op(fill(smax, bn, es), fill(smax, bm, es), es, 1, 0, 16, 1, "R3 smax+smax");
      run_op(fill(smin, bn, es), fill(umax, bm, es), es, 1, 0, 16, 1, "R3 smin+-1");
      run_op(fill(smin, bn, es), fill(64'd1, bm, es), es, 1, 1, 16, 1, "R3 smin-1");
      run_op(fill(smax, bn, es), fill(umax, bm, es), es, 1, 1, 16, 1, "R3 smax--1");
    end
  endtask

  task automatic t_inrange();
    for (int e = 0; e < 4; e++) begin
      logic [1:0]  es = 2'(e);
      int          w = 8 << e;
      logic [63:0] umax = (w == 64) ? '1 : (64'd1 << w) - 64'd1;
      logic [63:0] smax = umax >> 1;
      logic [63:0] smin = smax + 64'd1;
      run_op(fill(smax, smin, es), fill(smin, smax, es), es, 1, 0, 16, 1, "R4 smax+smin");
      run_op(fill(umax, 64'd5, es), fill(smax, 64'd5, es), es, 1, 1, 16, 0, "R4 -1-smax");
      run_op(fill(umax - 64'd1, 64'd7, es), fill(64'd1, 64'd9, es), es, 0, 0, 16, 0, "R4 umax-1+1");
      run_op(fill(64'd5, umax, es), fill(64'd5, umax, es), es, 0, 1, 16, 0, "R4 equal sub");
    end
  endtask

  task automatic t_widths();
    for (int e = 0; e < 4; e++)
      for (int m = 0; m < 4; m++)
        for (int rep = 0; rep < 3; rep++)
          run_op(rnd128(), rnd128(), 2'(e), m[1], m[0], 16, rep == 0, "R5 width/mode");
  endtask

  task automatic t_sticky();
    run_op({16{8'hF0}}, {16{8'h20}}, 0, 0, 0, 16, 1, "R6 saturate");
    run_op({16{8'h01}}, {16{8'h01}}, 0, 0, 0, 16, 0, "R6 hold after clean op");
    check("R6 expected flag set", {127'd0, sat_flag}, 128'd1);
  endtask

  task automatic t_clear();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0; exp_flag = 1'b0;
    check("R7 clear alone", {127'd0, sat_flag}, 128'd0);
    run_op({16{8'h7F}}, {16{8'h01}}, 0, 1, 0, 16, 1, "R7 clear with saturation");
    check("R7 set wins", {127'd0, sat_flag}, 128'd1);
  endtask

  task automatic t_tail();
    run_op({{8{8'hFF}}, {8{8'h01}}}, {16{8'h02}}, 0, 0, 0, 8, 1, "R8 half length");
    check("R8 dead lanes no flag", {127'd0, sat_flag}, 128'd0);
    run_op({16{8'h55}}, {16{8'h11}}, 3, 0, 0, 0, 0, "R8 zero length");
    run_op(rnd128(), rnd128(), 1, 1, 1, 8, 0, "R8 half length random");
  endtask

  task automatic t_latency();
    logic [127:0] held;
    held = result;
    repeat (3) @(negedge clk);
    check("R9 idle out_valid", {127'd0, out_valid}, 128'd0);
    check("R9 result holds", result, held);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #5;
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_boundaries();
    t_inrange();
    t_widths();
    t_sticky();
    t_clear();
    t_tail();
    t_latency();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule